// File: doc/BRIEF.md
# APB Serial Write Tunnel

This block sits on a local APB segment as a completer and carries each write across a point-to-point serial link to a far-side bus. A write access is packed into a fixed nine-symbol frame. The frame is a start control symbol, the low three address bytes, the four data bytes, and a CRC-8 byte. The frame leaves as a stream of byte-plus-control-flag symbols toward an external 8b/10b encoder and SERDES. Both link ends run at a rate fixed in advance, so there is no training or negotiation.

The tunnel is blocking. PREADY stays low after a write is taken until the far side answers with a two-symbol response: a response-start control symbol followed by a status byte. The status bit then sets PSLVERR in the single completion cycle. While no frame is in flight the transmit port carries an idle comma. Reads are not tunnelled and complete at once with an error.

The controller has five named states:
- IDLE: waits for an access phase.
- SEND: the frame is being streamed.
- AWAIT_START: waits for the response start.
- AWAIT_STATUS: waits for the status byte.
- COMPLETE: the one-cycle completion.

Transitions:
- IDLE→SEND on a write access phase.
- SEND→AWAIT_START when the CRC beat is accepted.
- AWAIT_START→AWAIT_STATUS on a K28.1.
- AWAIT_STATUS→COMPLETE on a data symbol.
- AWAIT_STATUS→AWAIT_START on any control symbol.
- COMPLETE→IDLE unconditionally.

Top module: `apb_serial_write_tunnel`

## Requirements
- R1: Whenever no frame is in progress, including straight after reset, tx_valid is 1 and the port carries the comma K28.5 (tx_data 0xBC, tx_is_k 1).
- R2: An access phase with psel, penable and pwrite high while IDLE starts a frame on the next cycle. The frame opens with K28.0 (0x1C, tx_is_k 1). Then come paddr[23:16], paddr[15:8] and paddr[7:0], then pwdata from most to least significant byte, all with tx_is_k 0. paddr bits above 23 have no effect on the frame.
- R3: The ninth symbol is a data byte holding CRC-8 of the seven address and data bytes in send order. The CRC uses polynomial 0x07, initial value 0x00 and most-significant-bit first. No end symbol follows: the comma returns on the cycle after the CRC is accepted.
- R4: A frame symbol advances only at a clock edge where tx_valid and tx_ready are both 1. Otherwise tx_data and tx_is_k hold.
- R5: pready stays 0 from the start of a write until its response completes. Received symbols are ignored while the frame is still being sent. While waiting for the start, any symbol other than K28.1 (0x3C, rx_is_k 1) is ignored.
- R6: After K28.1, the next valid data symbol (rx_is_k 0) is the status. On the following cycle pready is 1 for exactly one cycle, with pslverr equal to bit 0 of that status byte.
- R7: A control symbol received where the status is expected abandons that response, and the block waits for a fresh K28.1.
- R8: A read access phase (pwrite 0) while IDLE completes in the same cycle with pready 1 and pslverr 1, and sends no frame.
- R9: During reset pready is 0 and the transmit port carries the comma.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus and symbol streams |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 32 | APB address; low 24 bits are sent |
| pwdata | input | 32 | APB write data |
| pready | output | 1 | APB completion |
| pslverr | output | 1 | APB error with completion |
| tx_valid | output | 1 | Transmit symbol valid (always 1) |
| tx_ready | input | 1 | Transmit sink accepts the symbol |
| tx_data | output | 8 | Transmit symbol byte |
| tx_is_k | output | 1 | Transmit symbol is a control code |
| rx_valid | input | 1 | Receive symbol valid |
| rx_data | input | 8 | Receive symbol byte |
| rx_is_k | input | 1 | Receive symbol is a control code |

## Verification
The assertions assume the requester follows the APB handshake. It holds psel, pwrite, paddr and pwdata steady through a transfer, and it drops penable on the cycle after it sees pready. Without that, the one-cycle completion pulse could not be told apart from a second access. The bench's bus tasks do exactly that. The far-side responder only sends response symbols once the frame has finished, except in one scenario that injects a response start and status during the frame on purpose to show they are ignored.

// File: rtl/apb_tunnel_pkg.sv
`timescale 1ns/1ps
package apb_tunnel_pkg;

    localparam logic [7:0] SYM_FRAME_START = 8'h1C;  // K28.0
    localparam logic [7:0] SYM_RESP_START  = 8'h3C;  // K28.1
    localparam logic [7:0] SYM_IDLE_COMMA  = 8'hBC;  // K28.5
    localparam logic [7:0] CRC_POLY        = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_AWAIT_START,
        ST_AWAIT_STATUS,
        ST_COMPLETE
    } tun_state_e;

    // One byte folded into a running CRC, most significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] byte_in);
        logic [7:0] c;
        c = crc_in ^ byte_in;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/tun_crc8.sv
`timescale 1ns/1ps
module tun_crc8 #(
    parameter int N_BYTES = 7
) (
    input  logic [N_BYTES*8-1:0] msg,
    output logic [7:0]           crc
);
    import apb_tunnel_pkg::*;

    logic [7:0] chain [N_BYTES+1];

    assign chain[0] = 8'h00;

    generate
        for (genvar i = 0; i < N_BYTES; i++) begin : g_stage
            assign chain[i+1] = crc8_step(chain[i], msg[(N_BYTES-1-i)*8 +: 8]);
        end
    endgenerate

    assign crc = chain[N_BYTES];
endmodule

// File: rtl/tun_tx_framer.sv
`timescale 1ns/1ps
module tun_tx_framer #(
    parameter int PAY_BYTES = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [PAY_BYTES*8-1:0] payload,
    input  logic                   tx_ready,
    output logic                   tx_valid,
    output logic [7:0]             tx_data,
    output logic                   tx_is_k,
    output logic                   busy,
    output logic                   done
);
    import apb_tunnel_pkg::*;

    localparam int PAY_W     = PAY_BYTES * 8;
    localparam int FRAME_LEN = PAY_BYTES + 2;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [PAY_W-1:0] pay_q;
    logic [7:0]       crc_q;
    logic [7:0]       crc_w;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    logic             beat;

    tun_crc8 #(.N_BYTES(PAY_BYTES)) crc_i (
        .msg (payload),
        .crc (crc_w)
    );

    assign beat = busy_q && tx_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_q  <= '0;
            crc_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (load && !busy_q) begin
            pay_q  <= payload;
            crc_q  <= crc_w;
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (beat) begin
            if (idx_q == LAST_IDX) begin
                idx_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (idx_q != '0) begin
                    pay_q <= {pay_q[PAY_W-9:0], 8'h00};
                end
            end
        end
    end

    always_comb begin
        tx_valid = 1'b1;
        if (!busy_q) begin
            tx_data = SYM_IDLE_COMMA;
            tx_is_k = 1'b1;
        end else if (idx_q == '0) begin
            tx_data = SYM_FRAME_START;
            tx_is_k = 1'b1;
        end else if (idx_q == LAST_IDX) begin
            tx_data = crc_q;
            tx_is_k = 1'b0;
        end else begin
            tx_data = pay_q[PAY_W-1 -: 8];
            tx_is_k = 1'b0;
        end
    end

    assign busy = busy_q;
    assign done = beat && (idx_q == LAST_IDX);

    // Stalled frame symbol must not move.
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tx_ready) |=> ($stable(tx_data) && $stable(tx_is_k)));

    // After the CRC beat no trailer symbol: comma comes straight back.
    assert_no_trailer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (tx_is_k && tx_data == SYM_IDLE_COMMA));
endmodule

// File: rtl/tun_rx_decoder.sv
`timescale 1ns/1ps
module tun_rx_decoder (
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_is_k,
    output logic       resp_start,
    output logic       status_seen,
    output logic       ctrl_seen,
    output logic       status_err
);
    import apb_tunnel_pkg::*;

    always_comb begin
        resp_start  = rx_valid && rx_is_k && (rx_data == SYM_RESP_START);
        ctrl_seen   = rx_valid && rx_is_k;
        status_seen = rx_valid && !rx_is_k;
        status_err  = rx_data[0];
    end
endmodule

// File: rtl/apb_serial_write_tunnel.sv
`timescale 1ns/1ps
module apb_serial_write_tunnel #(
    parameter int ADDR_W          = 32,
    parameter int DATA_W          = 32,
    parameter int WIRE_ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic              pready,
    output logic              pslverr,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_is_k,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_is_k
);
    import apb_tunnel_pkg::*;

    localparam int WIRE_ADDR_W = WIRE_ADDR_BYTES * 8;
    localparam int DATA_BYTES  = DATA_W / 8;
    localparam int PAY_BYTES   = WIRE_ADDR_BYTES + DATA_BYTES;

    tun_state_e state_q, state_d;
    logic       err_q;

    logic wr_req, rd_req, frame_load;
    logic frame_busy, frame_done;
    logic resp_start, status_seen, ctrl_seen, status_err;
    logic unused_addr_hi;

    assign wr_req         = psel && penable && pwrite;
    assign rd_req         = psel && penable && !pwrite;
    assign frame_load     = (state_q == ST_IDLE) && wr_req;
    assign unused_addr_hi = ^paddr[ADDR_W-1:WIRE_ADDR_W];

    tun_tx_framer #(.PAY_BYTES(PAY_BYTES)) framer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_load),
        .payload  ({paddr[WIRE_ADDR_W-1:0], pwdata}),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_is_k  (tx_is_k),
        .busy     (frame_busy),
        .done     (frame_done)
    );

    tun_rx_decoder decoder_i (
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_is_k     (rx_is_k),
        .resp_start  (resp_start),
        .status_seen (status_seen),
        .ctrl_seen   (ctrl_seen),
        .status_err  (status_err)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (wr_req)      state_d = ST_SEND;
            ST_SEND:         if (frame_done)  state_d = ST_AWAIT_START;
            ST_AWAIT_START:  if (resp_start)  state_d = ST_AWAIT_STATUS;
            ST_AWAIT_STATUS: begin
                if (ctrl_seen)        state_d = ST_AWAIT_START;
                else if (status_seen) state_d = ST_COMPLETE;
            end
            ST_COMPLETE:     state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // State register and captured status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_AWAIT_STATUS && status_seen && !ctrl_seen) begin
                err_q <= status_err;
            end
        end
    end

    // Bus-side outputs.
    always_comb begin
        pready  = 1'b0;
        pslverr = 1'b0;
        unique case (state_q)
            ST_COMPLETE: begin
                pready  = 1'b1;
                pslverr = err_q;
            end
            ST_IDLE: begin
                if (rd_req) begin
                    pready  = 1'b1;
                    pslverr = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assert_idle_comma_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_busy |-> (tx_valid && tx_is_k && tx_data == SYM_IDLE_COMMA));

    assert_frame_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_busy) |-> (tx_is_k && tx_data == SYM_FRAME_START));

    assert_blocked_while_sending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_busy |-> !pready);

    assert_single_completion_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && pwrite) |=> !pready);

    assert_status_to_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && pwrite) |-> (pslverr == $past(rx_data[0])));

    assert_read_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state_q == ST_IDLE) |-> (pready && pslverr && !frame_load));
endmodule

// File: tb/apb_serial_write_tunnel_tb.sv
`timescale 1ns/1ps
module apb_serial_write_tunnel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0;
    logic        pready, pslverr;
    logic        tx_valid, tx_is_k;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0, rx_is_k = 1'b0;
    logic [7:0]  rx_data = '0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int resp_mode = 0;
    bit resp_err  = 0;
    bit ready_rand = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_serial_write_tunnel dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_is_k(tx_is_k),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_k(rx_is_k)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Serial bitwise CRC: feedback from top bit xor incoming bit.
    function automatic logic [7:0] ref_crc(input logic [55:0] msg);
        logic [7:0] r = 8'h00;
        for (int i = 55; i >= 0; i--) begin
            logic fb;
            fb = r[7] ^ msg[i];
            r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    // ---------------- reference model, compared every clock ----------------
    logic [8:0] q[$];
    int  m_state = 0;   // 0 idle, 1 send, 2 await start, 3 await status, 4 complete
    bit  m_err = 0;
    bit  m_stall = 0;
    bit  m_abort = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_stall = 0; m_abort = 0;
            q.delete();
        end else begin
            logic [8:0] exp_sym;
            string      tag;
            bit         exp_rdy, exp_err;
            if (m_state == 1) begin
                exp_sym = q[0];
                if (m_stall)            tag = "R4 stalled symbol held";
                else if (q.size() == 9) tag = "R2 frame start K28.0";
                else if (q.size() == 1) tag = "R3 crc byte";
                else                    tag = "R2 address/data byte";
            end else begin
                exp_sym = {1'b1, 8'hBC};
                tag = "R1 idle comma";
            end
            chk(tx_valid == 1'b1 && {tx_is_k, tx_data} == exp_sym, tag,
                {22'd0, tx_valid, tx_is_k, tx_data}, {22'd0, 1'b1, exp_sym});

            exp_rdy = (m_state == 4) || (m_state == 0 && psel && penable && !pwrite);
            exp_err = (m_state == 4) ? m_err : 1'b1;
            if (m_state >= 1 && m_state <= 3) tag = "R5 pready held low";
            else if (m_state == 4)            tag = m_abort ? "R7 completion after abort" : "R6 completion";
            else                              tag = (psel && penable && !pwrite) ? "R8 read rejected" : "R6 no stray pready";
            chk(pready == exp_rdy, tag, {31'd0, pready}, {31'd0, exp_rdy});
            if (exp_rdy)
                chk(pslverr == exp_err, {tag, " pslverr"}, {31'd0, pslverr}, {31'd0, exp_err});

            unique case (m_state)
                0: if (psel && penable && pwrite) begin
                    logic [55:0] msg;
                    msg = {paddr[23:0], pwdata};
                    q.delete();
                    q.push_back({1'b1, 8'h1C});
                    for (int i = 6; i >= 0; i--) q.push_back({1'b0, msg[i*8 +: 8]});
                    q.push_back({1'b0, ref_crc(msg)});
                    m_abort = 0; m_stall = 0;
                    m_state = 1;
                end
                1: begin
                    m_stall = !tx_ready;
                    if (tx_ready) begin
                        void'(q.pop_front());
                        if (q.size() == 0) m_state = 2;
                    end
                end
                2: if (rx_valid && rx_is_k && rx_data == 8'h3C) m_state = 3;
                3: if (rx_valid) begin
                    if (rx_is_k) begin m_state = 2; m_abort = 1; end
                    else begin m_err = rx_data[0]; m_state = 4; end
                end
                default: m_state = 0;
            endcase
        end
    end

    // ---------------- transmit sink back-pressure ----------------
    always @(posedge clk) begin
        #1 tx_ready <= ready_rand ? ($urandom % 3 != 0) : 1'b1;
    end

    // ---------------- far-side responder ----------------
    task automatic drive_rx(input bit v, input bit k, input logic [7:0] d);
        @(posedge clk); #1;
        rx_valid = v; rx_is_k = k; rx_data = d;
    endtask

    initial begin
        forever begin
            do @(negedge clk);
            while (!(rst_n && tx_valid && tx_ready && tx_is_k && tx_data == 8'h1C));
            if (resp_mode == 3) begin
                drive_rx(1, 1, 8'h3C);   // R5 early response ignored
                drive_rx(1, 0, 8'h01);
                drive_rx(0, 0, 8'h00);
            end
            do @(negedge clk); while (!(tx_is_k && tx_data == 8'hBC));
            repeat (2) @(posedge clk);
            if (resp_mode == 1) begin
                drive_rx(1, 0, 8'h55);   // stray data ignored
                drive_rx(1, 1, 8'hBC);   // stray comma ignored
                drive_rx(1, 1, 8'h3C);
                drive_rx(0, 1, 8'h3C);   // bubble
            end else if (resp_mode == 2) begin
                drive_rx(1, 1, 8'h3C);
                drive_rx(1, 1, 8'hBC);   // R7 abort
                drive_rx(1, 0, 8'h01);   // ignored while awaiting start
                drive_rx(1, 1, 8'h3C);
            end else begin
                drive_rx(1, 1, 8'h3C);
            end
            drive_rx(1, 0, {7'h55, resp_err});
            drive_rx(0, 0, 8'h00);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic apb_write(input logic [31:0] a, input logic [31:0] d,
                             input int mode, input bit err);
        resp_mode = mode; resp_err = err;
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        do @(negedge clk); while (!pready);
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    task automatic apb_read(input logic [31:0] a);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge clk); #1;
        penable = 1;
        do @(negedge clk); while (!pready);
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(pready == 1'b0, "R9 reset pready", {31'd0, pready}, 32'd0);
        chk(tx_valid && tx_is_k && tx_data == 8'hBC, "R9 reset comma",
            {23'd0, tx_is_k, tx_data}, {23'd0, 1'b1, 8'hBC});
        @(posedge clk); #1 rst_n = 1;
        repeat (3) @(posedge clk);

        apb_write(32'h00C0DE42, 32'h12345678, 0, 0);
        apb_write(32'hFF123456, 32'hA5A5A5A5, 0, 1);   // upper address bits ignored
        apb_read (32'h00000010);
        ready_rand = 1;
        apb_write(32'h00000000, 32'h00000000, 1, 0);
        apb_write(32'h7FFFFFFF, 32'hFFFFFFFF, 2, 1);
        apb_write(32'h00ABCDEF, 32'hDEADBEEF, 3, 0);
        apb_write(32'h00313233, 32'h34353637, 2, 0);
        apb_read (32'hFFFFFFFF);
        for (int i = 0; i < 40; i++) begin
            apb_write($urandom, $urandom, i % 4, bit'($urandom % 2));
            if (i % 7 == 0) apb_read($urandom);
        end
        ready_rand = 0;
        repeat (10) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule